// File: doc/BRIEF.md
# DDR2 Bank Activation Timing Tracker

The tracker observes a DDR2-style command bus made of chip select, row strobe, column strobe, write enable, a two-bit bank number and a 13-bit address. It recognises activate, read, write and precharge. For each of four banks it keeps whether a row is open, which row that is, and a set of per-bank down-counters. A shared counter spaces activates across banks. Each tracked command gets a verdict that says whether it is legal and, when it is not, which single rule it broke.

Reads and writes follow the posted-column model. A read or write may be presented before the row-to-column delay has run out, provided the programmed additive latency pushes its internal issue far enough back. An accepted read or write reappears on the issue outputs exactly that many clocks later, together with its bank, open row, column and direction. Every timing limit is a run-time input counted in clocks. A limit of 0 or 1 imposes no wait. All limits are meant to stay stable while commands flow.

A rejected command leaves all tracking state untouched. Refresh, mode programming, data bursts and strobe timing are not handled.

Top module: `ddr2_act_tracker`

## Requirements
- R1: With chip select low, {ras_n,cas_n,we_n} = 011 is activate, 101 is read, 100 is write and 010 is precharge. Any other pattern, or chip select high, gives cmd_vld_o = 0, cmd_ok_o = 0 and viol_o = 0 in the verdict cycle and changes no state.
- R2: An activate to an idle bank opens the row on addr. An activate to a bank with an open row is rejected with viol_o bit 1 (busy).
- R3: A read, write or precharge to an idle bank is rejected with viol_o bit 0 (no open row).
- R4: A read or write presented k clocks after the accepted activate of its bank is legal only when k + AL >= tRCD, where AL is cfg_al clamped to 4. Otherwise it is rejected with viol_o bit 2.
- R5: A precharge less than tRAS clocks after the bank's activate is rejected with viol_o bit 3.
- R6: An activate less than tRP clocks after the bank's accepted precharge is rejected with viol_o bit 4.
- R7: An activate less than tRC clocks after the previous accepted activate of the same bank is rejected with viol_o bit 5.
- R8: An activate less than tRRD clocks after the previous accepted activate to any bank is rejected with viol_o bit 6.
- R9: viol_o has at most one bit set. Priority for activate is busy, then tRP, then tRC, then tRRD. For read and write it is no-open-row, then tRCD. For precharge it is no-open-row, then tRAS.
- R10: A rejected command changes no bank state and does not restart any timer, including the shared tRRD timer.
- R11: An accepted read or write raises issue_vld_o for exactly one cycle, AL cycles after its verdict cycle. The pulse carries the bank, the open row, the column from addr, and issue_wr_o = 1 for a write.
- R12: After reset every output is zero, every bank is idle and every timer has expired, so an immediate activate is legal.
- R13: With tRCD = 3 and AL = 2, a read presented one clock after its activate is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank number |
| addr | input | 13 | Row on activate, column on read or write |
| cfg_trcd | input | 5 | Row-to-column delay in clocks |
| cfg_tras | input | 5 | Minimum activate-to-precharge time in clocks |
| cfg_trp | input | 5 | Minimum precharge-to-activate time in clocks |
| cfg_trc | input | 5 | Minimum activate-to-activate time, same bank, in clocks |
| cfg_trrd | input | 5 | Minimum activate-to-activate time, any bank, in clocks |
| cfg_al | input | 3 | Additive latency in clocks, clamped to 4 |
| cmd_vld_o | output | 1 | A tracked command was seen |
| cmd_ok_o | output | 1 | That command was legal |
| viol_o | output | 7 | One-hot rule violated |
| issue_vld_o | output | 1 | Internal read or write issue strobe |
| issue_wr_o | output | 1 | Issued command is a write |
| issue_bank_o | output | 2 | Bank of the issued command |
| issue_row_o | output | 13 | Open row of the issued command |
| issue_col_o | output | 13 | Column of the issued command |

## Verification
A command sampled at one rising edge has its verdict on cmd_vld_o, cmd_ok_o and viol_o right after that edge. Its issue strobe follows AL edges later, so with AL = 0 the strobe shares the verdict cycle. The bench drives each command at a falling edge and reads results at the next falling edge, so each step call returns with the verdict of the command it just drove. Issue strobes are checked after exactly AL further steps, and again one step later to confirm the pulse is a single cycle. Timing windows are probed one clock before and exactly at each limit, counted from the step that carried the opening command.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4
    } cmd_e;

    localparam int NV      = 7;
    localparam int V_NOROW = 0;
    localparam int V_BUSY  = 1;
    localparam int V_RCD   = 2;
    localparam int V_RAS   = 3;
    localparam int V_RP    = 4;
    localparam int V_RC    = 5;
    localparam int V_RRD   = 6;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);

    always_comb begin
        cmd_o = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer #(
    parameter int ADDR_W = 13,
    parameter int TW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              pre_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic [TW-1:0]     trcd_i,
    input  logic [TW-1:0]     tras_i,
    input  logic [TW-1:0]     trp_i,
    input  logic [TW-1:0]     trc_i,
    output logic              open_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [TW-1:0]     rcd_left_o,
    output logic              ras_done_o,
    output logic              rp_done_o,
    output logic              rc_done_o
);

    typedef struct packed {
        logic              open;
        logic [ADDR_W-1:0] row;
        logic [TW-1:0]     rcd;
        logic [TW-1:0]     ras;
        logic [TW-1:0]     rp;
        logic [TW-1:0]     rc;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [TW-1:0] dec_sat(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dec_sat(st_q.rcd);
        st_d.ras = dec_sat(st_q.ras);
        st_d.rp  = dec_sat(st_q.rp);
        st_d.rc  = dec_sat(st_q.rc);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.row  = row_i;
            st_d.rcd  = dec_sat(trcd_i);
            st_d.ras  = dec_sat(tras_i);
            st_d.rc   = dec_sat(trc_i);
        end else if (pre_i) begin
            st_d.open = 1'b0;
            st_d.rp   = dec_sat(trp_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o     = st_q.open;
    assign row_o      = st_q.row;
    assign rcd_left_o = st_q.rcd;
    assign ras_done_o = (st_q.ras == '0);
    assign rp_done_o  = (st_q.rp == '0);
    assign rc_done_o  = (st_q.rc == '0);

endmodule

// File: rtl/ddr2_posted_cas.sv
module ddr2_posted_cas #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int MAX_AL = 4,
    parameter int ALW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              wr_i,
    input  logic [BA_W-1:0]   bank_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic [ADDR_W-1:0] col_i,
    input  logic [ALW-1:0]    al_i,
    output logic              issue_vld_o,
    output logic              issue_wr_o,
    output logic [BA_W-1:0]   issue_bank_o,
    output logic [ADDR_W-1:0] issue_row_o,
    output logic [ADDR_W-1:0] issue_col_o
);

    localparam int DEPTH = MAX_AL + 1;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
    } slot_t;

    slot_t [DEPTH-1:0] line_d, line_q;

    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            line_d[i] = line_q[i+1];
        end
        line_d[DEPTH-1] = '0;
        if (push_i) begin
            line_d[al_i] = '{vld: 1'b1, wr: wr_i, bank: bank_i, row: row_i, col: col_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign issue_vld_o  = line_q[0].vld;
    assign issue_wr_o   = line_q[0].wr;
    assign issue_bank_o = line_q[0].bank;
    assign issue_row_o  = line_q[0].row;
    assign issue_col_o  = line_q[0].col;

endmodule

// File: rtl/ddr2_act_tracker.sv
module ddr2_act_tracker
    import ddr2_trk_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 13,
    parameter int TW     = 5,
    parameter int ALW    = 3,
    parameter int MAX_AL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [TW-1:0]     cfg_tras,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trc,
    input  logic [TW-1:0]     cfg_trrd,
    input  logic [ALW-1:0]    cfg_al,
    output logic              cmd_vld_o,
    output logic              cmd_ok_o,
    output logic [NV-1:0]     viol_o,
    output logic              issue_vld_o,
    output logic              issue_wr_o,
    output logic [BA_W-1:0]   issue_bank_o,
    output logic [ADDR_W-1:0] issue_row_o,
    output logic [ADDR_W-1:0] issue_col_o
);

    localparam int NUM_BANKS = 1 << BA_W;

    typedef struct packed {
        logic [TW-1:0] rrd;
        logic          vld;
        logic          ok;
        logic [NV-1:0] viol;
    } top_st_t;

    top_st_t st_d, st_q;

    cmd_e                               cmd;
    logic [NUM_BANKS-1:0]               act_go;
    logic [NUM_BANKS-1:0]               pre_go;
    logic [NUM_BANKS-1:0]               bk_open;
    logic [NUM_BANKS-1:0]               bk_ras_done;
    logic [NUM_BANKS-1:0]               bk_rp_done;
    logic [NUM_BANKS-1:0]               bk_rc_done;
    logic [NUM_BANKS-1:0][TW-1:0]       bk_rcd_left;
    logic [NUM_BANKS-1:0][ADDR_W-1:0]   bk_row;
    logic [NV-1:0]                      viol;
    logic                               legal;
    logic                               push;
    logic [ALW-1:0]                     al_eff;

    function automatic logic [TW-1:0] dec_sat(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    ddr2_cmd_decode i_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            ddr2_bank_timer #(
                .ADDR_W (ADDR_W),
                .TW     (TW)
            ) i_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .act_i      (act_go[b]),
                .pre_i      (pre_go[b]),
                .row_i      (addr),
                .trcd_i     (cfg_trcd),
                .tras_i     (cfg_tras),
                .trp_i      (cfg_trp),
                .trc_i      (cfg_trc),
                .open_o     (bk_open[b]),
                .row_o      (bk_row[b]),
                .rcd_left_o (bk_rcd_left[b]),
                .ras_done_o (bk_ras_done[b]),
                .rp_done_o  (bk_rp_done[b]),
                .rc_done_o  (bk_rc_done[b])
            );
        end
    endgenerate

    // Additive latency beyond the supported maximum is clamped.
    assign al_eff = (cfg_al > ALW'(MAX_AL)) ? ALW'(MAX_AL) : cfg_al;

    // Rule checks, in priority order, for the command on the bus.
    always_comb begin
        viol = '0;
        unique case (cmd)
            CMD_ACT: begin
                if (bk_open[ba])               viol[V_BUSY] = 1'b1;
                else if (!bk_rp_done[ba])      viol[V_RP]   = 1'b1;
                else if (!bk_rc_done[ba])      viol[V_RC]   = 1'b1;
                else if (st_q.rrd != '0)       viol[V_RRD]  = 1'b1;
            end
            CMD_RD, CMD_WR: begin
                if (!bk_open[ba])                          viol[V_NOROW] = 1'b1;
                else if (bk_rcd_left[ba] > TW'(al_eff))    viol[V_RCD]   = 1'b1;
            end
            CMD_PRE: begin
                if (!bk_open[ba])              viol[V_NOROW] = 1'b1;
                else if (!bk_ras_done[ba])     viol[V_RAS]   = 1'b1;
            end
            default: viol = '0;
        endcase
    end

    assign legal = (cmd != CMD_NONE) && (viol == '0);
    assign push  = legal && ((cmd == CMD_RD) || (cmd == CMD_WR));

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            act_go[i] = legal && (cmd == CMD_ACT) && (ba == BA_W'(i));
            pre_go[i] = legal && (cmd == CMD_PRE) && (ba == BA_W'(i));
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = (cmd != CMD_NONE);
        st_d.ok   = legal;
        st_d.viol = viol;
        if (legal && (cmd == CMD_ACT)) begin
            st_d.rrd = dec_sat(cfg_trrd);
        end else begin
            st_d.rrd = dec_sat(st_q.rrd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld_o = st_q.vld;
    assign cmd_ok_o  = st_q.ok;
    assign viol_o    = st_q.viol;

    ddr2_posted_cas #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .MAX_AL (MAX_AL),
        .ALW    (ALW)
    ) i_posted (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .wr_i         (cmd == CMD_WR),
        .bank_i       (ba),
        .row_i        (bk_row[ba]),
        .col_i        (addr),
        .al_i         (al_eff),
        .issue_vld_o  (issue_vld_o),
        .issue_wr_o   (issue_wr_o),
        .issue_bank_o (issue_bank_o),
        .issue_row_o  (issue_row_o),
        .issue_col_o  (issue_col_o)
    );

endmodule

// File: rtl/ddr2_act_tracker_chk.sv
module ddr2_act_tracker_chk #(
    parameter int BA_W = 2,
    parameter int TW   = 5,
    parameter int ALW  = 3,
    parameter int NV   = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [BA_W-1:0] ba,
    input logic [TW-1:0]   cfg_trcd,
    input logic [TW-1:0]   cfg_trrd,
    input logic [ALW-1:0]  cfg_al,
    input logic            cmd_vld_o,
    input logic            cmd_ok_o,
    input logic [NV-1:0]   viol_o,
    input logic            issue_vld_o
);

    logic bus_act;
    logic bus_rdwr;
    assign bus_act  = !cs_n && !ras_n && cas_n && we_n;
    assign bus_rdwr = !cs_n && ras_n && !cas_n;

    // R9: never more than one violation reported
    p_viol_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(viol_o));

    // R1: untracked bus cycles give an empty verdict
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld_o |-> (viol_o == '0) && !cmd_ok_o);

    // R1: a deselected bus cycle is never tracked
    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !cmd_vld_o);

    // R9: a tracked command is either accepted or carries a reason
    p_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_ok_o != (viol_o != '0)));

    // R8: two accepted activates on back-to-back clocks need tRRD below 2
    p_rrd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok_o && $past(bus_act) && cfg_trrd >= TW'(2))
        |-> !($past(cmd_ok_o) && $past(bus_act, 2)));

    // R4: with no additive latency a column command cannot follow its activate at once
    p_rcd_al0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok_o && $past(bus_rdwr) && cfg_al == '0 && cfg_trcd >= TW'(2))
        |-> !($past(cmd_ok_o) && $past(bus_act, 2) && $past(ba) == $past(ba, 2)));

    // R11: with no additive latency the issue strobe shares the verdict cycle
    p_issue_al0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok_o && $past(bus_rdwr) && cfg_al == '0) |-> issue_vld_o);

endmodule

bind ddr2_act_tracker ddr2_act_tracker_chk #(
    .BA_W (BA_W),
    .TW   (TW),
    .ALW  (ALW),
    .NV   (ddr2_trk_pkg::NV)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .cfg_trcd    (cfg_trcd),
    .cfg_trrd    (cfg_trrd),
    .cfg_al      (cfg_al),
    .cmd_vld_o   (cmd_vld_o),
    .cmd_ok_o    (cmd_ok_o),
    .viol_o      (viol_o),
    .issue_vld_o (issue_vld_o)
);

// File: tb/test_ddr2_act_tracker.sv
module test_ddr2_act_tracker;

    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_MRS = 3'b000;

    localparam logic [6:0] V_NONE  = 7'h00;
    localparam logic [6:0] V_NOROW = 7'h01;
    localparam logic [6:0] V_BUSY  = 7'h02;
    localparam logic [6:0] V_RCD   = 7'h04;
    localparam logic [6:0] V_RAS   = 7'h08;
    localparam logic [6:0] V_RP    = 7'h10;
    localparam logic [6:0] V_RC    = 7'h20;
    localparam logic [6:0] V_RRD   = 7'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [4:0]  cfg_trcd = 5'd3;
    logic [4:0]  cfg_tras = 5'd6;
    logic [4:0]  cfg_trp = 5'd3;
    logic [4:0]  cfg_trc = 5'd9;
    logic [4:0]  cfg_trrd = 5'd2;
    logic [2:0]  cfg_al = 3'd2;
    logic        cmd_vld_o;
    logic        cmd_ok_o;
    logic [6:0]  viol_o;
    logic        issue_vld_o;
    logic        issue_wr_o;
    logic [1:0]  issue_bank_o;
    logic [12:0] issue_row_o;
    logic [12:0] issue_col_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ddr2_act_tracker i_ddr2_act_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .addr         (addr),
        .cfg_trcd     (cfg_trcd),
        .cfg_tras     (cfg_tras),
        .cfg_trp      (cfg_trp),
        .cfg_trc      (cfg_trc),
        .cfg_trrd     (cfg_trrd),
        .cfg_al       (cfg_al),
        .cmd_vld_o    (cmd_vld_o),
        .cmd_ok_o     (cmd_ok_o),
        .viol_o       (viol_o),
        .issue_vld_o  (issue_vld_o),
        .issue_wr_o   (issue_wr_o),
        .issue_bank_o (issue_bank_o),
        .issue_row_o  (issue_row_o),
        .issue_col_o  (issue_col_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic verdict(input string what, input logic ok, input logic [6:0] v);
        chk({what, " ok"}, 32'(cmd_ok_o), 32'(ok));
        chk({what, " viol"}, 32'(viol_o), 32'(v));
    endtask

    // Drive one bus cycle at a falling edge; return at the next falling edge.
    task automatic step(input logic [2:0] rcw, input logic [1:0] b,
                        input logic [12:0] a, input logic csn = 1'b0);
        cs_n = csn;
        {ras_n, cas_n, we_n} = rcw;
        ba = b;
        addr = a;
        @(negedge clk);
        cs_n = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(C_NOP, 2'd0, 13'd0, 1'b1);
    endtask

    task automatic restart(input logic [4:0] rcd, input logic [4:0] ras, input logic [4:0] rp,
                           input logic [4:0] rc, input logic [4:0] rrd, input logic [2:0] al);
        cfg_trcd = rcd; cfg_tras = ras; cfg_trp = rp;
        cfg_trc = rc; cfg_trrd = rrd; cfg_al = al;
        rst_n = 1'b0;
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd2);
        chk("R12 vld after reset", 32'(cmd_vld_o), 32'd0);
        chk("R12 ok after reset", 32'(cmd_ok_o), 32'd0);
        chk("R12 viol after reset", 32'(viol_o), 32'd0);
        chk("R12 issue after reset", 32'(issue_vld_o), 32'd0);
        step(C_ACT, 2'd3, 13'h011);
        verdict("R12 first activate", 1'b1, V_NONE);
        chk("R12 R2 vld on activate", 32'(cmd_vld_o), 32'd1);
    endtask

    task automatic t_reference;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd2);
        step(C_ACT, 2'd1, 13'h123);
        verdict("R2 activate bank1", 1'b1, V_NONE);
        step(C_RD, 2'd1, 13'h045);
        verdict("R13 read one clock after activate", 1'b1, V_NONE);
        chk("R11 no issue at verdict", 32'(issue_vld_o), 32'd0);
        idle(1);
        chk("R11 no issue after 1", 32'(issue_vld_o), 32'd0);
        idle(1);
        chk("R11 issue after AL=2", 32'(issue_vld_o), 32'd1);
        chk("R11 issue bank", 32'(issue_bank_o), 32'd1);
        chk("R11 issue row", 32'(issue_row_o), 32'h123);
        chk("R11 issue col", 32'(issue_col_o), 32'h045);
        chk("R11 issue read", 32'(issue_wr_o), 32'd0);
        idle(1);
        chk("R11 issue single pulse", 32'(issue_vld_o), 32'd0);
    endtask

    task automatic t_rcd;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd0);
        step(C_ACT, 2'd2, 13'h0aa);
        step(C_WR, 2'd2, 13'h007);
        verdict("R4 write k=1 AL=0", 1'b0, V_RCD);
        chk("R11 R10 no issue for rejected write", 32'(issue_vld_o), 32'd0);
        idle(1);
        step(C_WR, 2'd2, 13'h007);
        verdict("R4 write k=3 AL=0", 1'b1, V_NONE);
        chk("R11 issue with AL=0", 32'(issue_vld_o), 32'd1);
        chk("R11 issue write flag", 32'(issue_wr_o), 32'd1);
        chk("R11 issue row AL=0", 32'(issue_row_o), 32'h0aa);
        restart(5'd5, 5'd6, 5'd3, 5'd9, 5'd2, 3'd4);
        step(C_ACT, 2'd0, 13'h001);
        step(C_RD, 2'd0, 13'h002);
        verdict("R4 read k=1 AL=4 tRCD=5", 1'b1, V_NONE);
        restart(5'd6, 5'd6, 5'd3, 5'd9, 5'd2, 3'd4);
        step(C_ACT, 2'd0, 13'h001);
        step(C_RD, 2'd0, 13'h002);
        verdict("R4 read k=1 AL=4 tRCD=6", 1'b0, V_RCD);
        step(C_RD, 2'd0, 13'h002);
        verdict("R4 read k=2 AL=4 tRCD=6", 1'b1, V_NONE);
    endtask

    task automatic t_norow;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd2);
        step(C_RD, 2'd0, 13'h000);
        verdict("R3 read idle bank", 1'b0, V_NOROW);
        step(C_WR, 2'd1, 13'h000);
        verdict("R3 write idle bank", 1'b0, V_NOROW);
        step(C_PRE, 2'd2, 13'h000);
        verdict("R3 precharge idle bank", 1'b0, V_NOROW);
        step(C_ACT, 2'd3, 13'h055, 1'b1);
        chk("R1 deselected activate vld", 32'(cmd_vld_o), 32'd0);
        verdict("R1 deselected activate", 1'b0, V_NONE);
        step(C_NOP, 2'd3, 13'h055);
        chk("R1 NOP vld", 32'(cmd_vld_o), 32'd0);
        step(C_MRS, 2'd3, 13'h055);
        chk("R1 untracked pattern vld", 32'(cmd_vld_o), 32'd0);
        step(C_RD, 2'd3, 13'h000);
        verdict("R1 bank3 still idle", 1'b0, V_NOROW);
        idle(3);
        chk("R11 no issue from rejected reads", 32'(issue_vld_o), 32'd0);
    endtask

    task automatic t_ras_rp;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd2);
        step(C_ACT, 2'd0, 13'h0f0);
        idle(4);
        step(C_PRE, 2'd0, 13'h000);
        verdict("R5 precharge k=5 tRAS=6", 1'b0, V_RAS);
        step(C_RD, 2'd0, 13'h003);
        verdict("R10 row still open after rejected precharge", 1'b1, V_NONE);
        step(C_PRE, 2'd0, 13'h000);
        verdict("R5 precharge k=7", 1'b1, V_NONE);
        idle(1);
        step(C_ACT, 2'd0, 13'h0f1);
        verdict("R6 activate 2 after precharge tRP=3", 1'b0, V_RP);
        step(C_ACT, 2'd0, 13'h0f1);
        verdict("R6 activate 3 after precharge", 1'b1, V_NONE);
    endtask

    task automatic t_rc;
        restart(5'd1, 5'd3, 5'd2, 5'd12, 5'd1, 3'd0);
        step(C_ACT, 2'd1, 13'h010);
        idle(2);
        step(C_PRE, 2'd1, 13'h000);
        verdict("R5 precharge k=3 tRAS=3", 1'b1, V_NONE);
        idle(1);
        step(C_ACT, 2'd1, 13'h011);
        verdict("R7 activate k=5 tRC=12", 1'b0, V_RC);
        idle(6);
        step(C_ACT, 2'd1, 13'h012);
        verdict("R7 activate k=12", 1'b1, V_NONE);
        step(C_ACT, 2'd1, 13'h013);
        verdict("R9 busy ahead of tRC", 1'b0, V_BUSY);
    endtask

    task automatic t_rrd;
        restart(5'd3, 5'd6, 5'd3, 5'd9, 5'd2, 3'd2);
        step(C_ACT, 2'd0, 13'h100);
        verdict("R8 first activate", 1'b1, V_NONE);
        step(C_ACT, 2'd1, 13'h101);
        verdict("R8 activate other bank k=1 tRRD=2", 1'b0, V_RRD);
        step(C_ACT, 2'd1, 13'h101);
        verdict("R8 activate other bank k=2", 1'b1, V_NONE);
        step(C_ACT, 2'd0, 13'h102);
        verdict("R2 R9 busy ahead of tRRD", 1'b0, V_BUSY);
        step(C_ACT, 2'd2, 13'h103);
        verdict("R10 rejected activate did not restart tRRD", 1'b1, V_NONE);
    endtask

    initial begin
        t_reset();
        t_reference();
        t_rcd();
        t_norow();
        t_ras_rp();
        t_rc();
        t_rrd();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule